// File: doc/BRIEF.md
# Boundary Scan Data Register Chain

This block is the boundary data register of an IEEE 1149.1 test chain for a parameterised number of bidirectional pad sites. Each pad site has three scan cells: the value seen at the pad, the value to drive, and the drive enable. Three non-pin cells are added at fixed places. Chain bit 0 holds the test-data-out enable, bit 1 holds the test-data-out value, and the top bit reports whether an update has happened since test reset. Dedicated configuration pins are not part of the chain. With `NUM_PADS` pads the chain is `3*NUM_PADS+3` bits long.

An external TAP controller supplies the capture, shift and update strobes and the EXTEST mode select. All of these are sampled on the rising test clock. Serial data enters at the top bit and leaves from bit 0. Each pad's output and enable cells have an update latch. When EXTEST is selected, these latches drive the pad. Otherwise the pad follows the core. The incoming pad value always passes straight through to the core.

Top module: `bscan_chain`

## Requirements
- R1: The chain is exactly `3*NUM_PADS+3` bits long. A bit entered on `tdi_i` reaches `tdo_o` after that many shift edges.
- R2: While `rst_ni` is low, all chain cells, update latches and the update-status flag are cleared. Under EXTEST after reset, `pad_out_o` and `pad_oe_o` are all zero.
- R3: With `extest_i` low, `pad_out_o` equals `core_out_i` and `pad_oe_o` equals `core_oe_i`. At all times `core_in_o` equals `pad_in_i`.
- R4: On a rising `tck_i` edge with `capture_i` high, pad k's cells load together. Bit 3k+2 loads `pad_in_i[k]`, bit 3k+3 loads `pad_out_o[k]` and bit 3k+4 loads `pad_oe_o[k]`.
- R5: On a capture edge, bit 0 loads 0 and bit 1 loads 1.
- R6: On a capture edge, the top bit loads the update-status flag. The flag is 0 until the first update edge after reset and 1 from then on.
- R7: On an edge with `shift_i` high and `capture_i` low, bit i loads bit i+1 and the top bit loads `tdi_i`. `tdo_o` always shows bit 0.
- R8: On an edge with `update_i` high, each pad's output latch loads bit 3k+3 and its enable latch loads bit 3k+4. Under EXTEST these latches drive `pad_out_o[k]` and `pad_oe_o[k]`.
- R9: When `capture_i` and `shift_i` are both high, capture takes priority.
- R10: The chain holds its value on edges without capture or shift. The update latches hold their value on edges without update, and shifting or capturing does not change them.
- R11: When update and shift fall on the same edge, the latches load the chain contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous test reset, active low |
| capture_i | input | 1 | Capture strobe (Capture-DR) |
| shift_i | input | 1 | Shift strobe (Shift-DR) |
| update_i | input | 1 | Update strobe (Update-DR) |
| extest_i | input | 1 | EXTEST selected: pads driven from update latches |
| tdi_i | input | 1 | Serial data in, enters at top bit |
| tdo_o | output | 1 | Serial data out, chain bit 0 |
| pad_in_i | input | NUM_PADS | Value seen at each pad |
| core_in_o | output | NUM_PADS | Pad value passed to the core |
| core_out_i | input | NUM_PADS | Core output data |
| core_oe_i | input | NUM_PADS | Core output enable |
| pad_out_o | output | NUM_PADS | Data to pad driver |
| pad_oe_o | output | NUM_PADS | Enable to pad driver |

## Verification
Two function pairs can fall on the same clock edge: capture with shift, and update with shift. For the first pair, the bench raises capture and shift together on one edge. It then scans the chain out and checks that it holds the captured image rather than shifted data. For the second pair, a known pattern is loaded and then one edge carries both shift and update. The pad outputs under EXTEST must show the pattern as it stood before that edge, not the shifted one.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  function automatic int chain_len(input int n_pads);
    return 3 * n_pads + 3;
  endfunction
  function automatic int in_idx(input int k);
    return 3 * k + 2;
  endfunction
  function automatic int out_idx(input int k);
    return 3 * k + 3;
  endfunction
  function automatic int oe_idx(input int k);
    return 3 * k + 4;
  endfunction
  localparam int TDO_OE_IDX  = 0;
  localparam int TDO_VAL_IDX = 1;
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
  parameter bit HAS_UPD = 1'b1
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic cap_d_i,
  input  logic shift_d_i,
  output logic q_o,
  output logic upd_q_o
);
  logic q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        q <= 1'b0;
    else if (capture_i) q <= cap_d_i;
    else if (shift_i)   q <= shift_d_i;
  end
  assign q_o = q;

  p_cap_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> q == $past(cap_d_i));
  p_shift_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> q == $past(shift_d_i));
  p_hold_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!shift_i && !capture_i) |=> $stable(q));

  if (HAS_UPD) begin : g_upd
    logic upd_q;
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)       upd_q <= 1'b0;
      else if (update_i) upd_q <= q;
    end
    assign upd_q_o = upd_q;

    p_upd_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
      update_i |=> upd_q_o == $past(q_o));
    p_upd_hold_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
      !update_i |=> $stable(upd_q_o));
  end else begin : g_no_upd
    assign upd_q_o = 1'b0;
  end
endmodule

// File: rtl/bscan_upd_flag.sv
module bscan_upd_flag (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic update_i,
  output logic seen_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       seen_o <= 1'b0;
    else if (update_i) seen_o <= 1'b1;
  end

  p_flag_set_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    update_i |=> seen_o);
  p_flag_sticky_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    seen_o |=> seen_o);
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_PADS = 4
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic                shift_i,
  input  logic                update_i,
  input  logic                extest_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  input  logic [NUM_PADS-1:0] pad_in_i,
  output logic [NUM_PADS-1:0] core_in_o,
  input  logic [NUM_PADS-1:0] core_out_i,
  input  logic [NUM_PADS-1:0] core_oe_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o
);
  localparam int LEN = chain_len(NUM_PADS);
  localparam int TOP = LEN - 1;

  logic [LEN-1:0] chain;
  logic [LEN-1:0] shift_in;
  logic [LEN-1:0] cap_val;
  logic [LEN-1:0] upd_val;
  logic           upd_seen;

  // serial path runs from the top bit down toward bit 0
  assign shift_in = {tdi_i, chain[LEN-1:1]};
  assign tdo_o    = chain[0];
  assign core_in_o = pad_in_i;

  bscan_upd_flag u_flag (
    .tck_i(tck_i), .rst_ni(rst_ni), .update_i(update_i), .seen_o(upd_seen)
  );

  assign cap_val[TDO_OE_IDX]  = 1'b0;
  assign cap_val[TDO_VAL_IDX] = 1'b1;
  assign cap_val[TOP]         = upd_seen;

  for (genvar s = 0; s < 3; s++) begin : g_special
    localparam int IDX = (s == 2) ? TOP : s;
    bscan_cell #(.HAS_UPD(1'b0)) u_cell (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_i),
      .shift_i(shift_i), .update_i(update_i),
      .cap_d_i(cap_val[IDX]), .shift_d_i(shift_in[IDX]),
      .q_o(chain[IDX]), .upd_q_o(upd_val[IDX])
    );
  end

  for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
    localparam int I_IN  = in_idx(k);
    localparam int I_OUT = out_idx(k);
    localparam int I_OE  = oe_idx(k);

    assign cap_val[I_IN]  = pad_in_i[k];
    assign cap_val[I_OUT] = pad_out_o[k];
    assign cap_val[I_OE]  = pad_oe_o[k];

    bscan_cell #(.HAS_UPD(1'b0)) u_in (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_i),
      .shift_i(shift_i), .update_i(update_i),
      .cap_d_i(cap_val[I_IN]), .shift_d_i(shift_in[I_IN]),
      .q_o(chain[I_IN]), .upd_q_o(upd_val[I_IN])
    );
    bscan_cell #(.HAS_UPD(1'b1)) u_out (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_i),
      .shift_i(shift_i), .update_i(update_i),
      .cap_d_i(cap_val[I_OUT]), .shift_d_i(shift_in[I_OUT]),
      .q_o(chain[I_OUT]), .upd_q_o(upd_val[I_OUT])
    );
    bscan_cell #(.HAS_UPD(1'b1)) u_oe (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_i),
      .shift_i(shift_i), .update_i(update_i),
      .cap_d_i(cap_val[I_OE]), .shift_d_i(shift_in[I_OE]),
      .q_o(chain[I_OE]), .upd_q_o(upd_val[I_OE])
    );

    assign pad_out_o[k] = extest_i ? upd_val[I_OUT] : core_out_i[k];
    assign pad_oe_o[k]  = extest_i ? upd_val[I_OE]  : core_oe_i[k];
  end

  p_tdo_step_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> tdo_o == $past(chain[1]));
  p_top_load_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> chain[TOP] == $past(tdi_i));
  p_cap_prio_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && capture_i) |=> chain[TDO_VAL_IDX] && !chain[TDO_OE_IDX]);
endmodule

// File: tb/bscan_chain_tb_top.sv
module bscan_chain_tb_top;
  localparam int N = 4;
  localparam int L = 3 * N + 3;

  logic tck = 1'b0, rst_n = 1'b0;
  logic capture = 0, shift = 0, update = 0, extest = 0, tdi = 0;
  logic tdo;
  logic [N-1:0] pad_in = '0, core_out = '0, core_oe = '0;
  logic [N-1:0] core_in, pad_out, pad_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 tck = ~tck;

  bscan_chain #(.NUM_PADS(N)) dut_i (
    .tck_i(tck), .rst_ni(rst_n), .capture_i(capture), .shift_i(shift),
    .update_i(update), .extest_i(extest), .tdi_i(tdi), .tdo_o(tdo),
    .pad_in_i(pad_in), .core_in_o(core_in), .core_out_i(core_out),
    .core_oe_i(core_oe), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] cap_img(input logic [N-1:0] pin,
      input logic [N-1:0] pout, input logic [N-1:0] poe, input logic flag);
    logic [L-1:0] v = '0;
    v[0] = 1'b0;
    v[1] = 1'b1;
    for (int k = 0; k < N; k++) begin
      v[3*k+2] = pin[k];
      v[3*k+3] = pout[k];
      v[3*k+4] = poe[k];
    end
    v[L-1] = flag;
    return v;
  endfunction

  function automatic logic [N-1:0] f_out(input logic [L-1:0] v);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = v[3*k+3];
    return r;
  endfunction

  function automatic logic [N-1:0] f_oe(input logic [L-1:0] v);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = v[3*k+4];
    return r;
  endfunction

  // called at a falling edge; bit j of vout is tdo before the j-th shift edge
  task automatic scan(input logic [L-1:0] vin, output logic [L-1:0] vout);
    for (int j = 0; j < L; j++) begin
      tdi = vin[j];
      shift = 1'b1;
      vout[j] = tdo;
      @(posedge tck);
      @(negedge tck);
    end
    shift = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic pulse(input logic c, input logic s, input logic u);
    capture = c; shift = s; update = u;
    @(posedge tck);
    @(negedge tck);
    capture = 0; shift = 0; update = 0;
  endtask

  task automatic t_reset;
    extest = 1'b1;
    #1;
    chk(tdo == 1'b0, "R2 tdo", tdo, 0);
    chk(pad_oe == '0, "R2 pad_oe", pad_oe, 0);
    chk(pad_out == '0, "R2 pad_out", pad_out, 0);
    extest = 1'b0;
  endtask

  task automatic t_core_path;
    for (int i = 0; i < 3; i++) begin
      core_out = N'(4'b1010 ^ i); core_oe = N'(4'b0110 + i); pad_in = N'(4'b1100 - i);
      #1;
      chk(pad_out == core_out && pad_oe == core_oe && core_in == pad_in,
          "R3 core path", {pad_out, pad_oe, core_in}, {core_out, core_oe, pad_in});
      @(negedge tck);
    end
  endtask

  task automatic t_capture;
    logic [L-1:0] got;
    extest = 0; pad_in = 4'b1001; core_out = 4'b0101; core_oe = 4'b0011;
    @(negedge tck);
    pulse(1, 0, 0);
    scan('0, got);
    chk(got == cap_img(4'b1001, 4'b0101, 4'b0011, 1'b0), "R4 R5 R6 capture image",
        got, cap_img(4'b1001, 4'b0101, 4'b0011, 1'b0));
    chk(got[L-1] == 1'b0, "R6 flag before update", got[L-1], 0);
  endtask

  task automatic t_length;
    logic [L-1:0] a, b, got;
    a = 15'h5a3c; b = 15'h1e71;
    scan(a, got);
    scan(b, got);
    chk(got == a, "R1 round trip length", got, a);
    repeat (3) @(negedge tck);
    scan(a, got);
    chk(got == b, "R10 hold between scans", got, b);
  endtask

  task automatic t_update;
    logic [L-1:0] a, got;
    a = 15'h36d9;
    scan(a, got);
    pulse(0, 0, 1);
    extest = 1'b1;
    #1;
    chk(pad_out == f_out(a), "R8 pad_out", pad_out, f_out(a));
    chk(pad_oe == f_oe(a), "R8 pad_oe", pad_oe, f_oe(a));
    scan(15'h7fff ^ a, got);
    pulse(1, 0, 0);
    #1;
    chk(pad_out == f_out(a) && pad_oe == f_oe(a), "R10 latches ignore shift/capture",
        {pad_out, pad_oe}, {f_out(a), f_oe(a)});
    pad_in = 4'b0110;
    pulse(1, 0, 0);
    scan('0, got);
    chk(got == cap_img(4'b0110, f_out(a), f_oe(a), 1'b1), "R4 R6 extest capture",
        got, cap_img(4'b0110, f_out(a), f_oe(a), 1'b1));
    extest = 1'b0;
  endtask

  task automatic t_priority;
    logic [L-1:0] got;
    pad_in = 4'b0011; core_out = 4'b1110; core_oe = 4'b1000;
    scan(15'h2aaa, got);
    tdi = 1'b1;
    pulse(1, 1, 0);
    tdi = 1'b0;
    scan('0, got);
    chk(got == cap_img(4'b0011, 4'b1110, 4'b1000, 1'b1), "R9 capture over shift",
        got, cap_img(4'b0011, 4'b1110, 4'b1000, 1'b1));
  endtask

  task automatic t_upd_shift;
    logic [L-1:0] a, b, got;
    a = 15'h4c93; b = 15'h33b4;
    scan(b, got);
    pulse(0, 0, 1);
    scan(a, got);
    tdi = 1'b1;
    pulse(0, 1, 1);
    tdi = 1'b0;
    extest = 1'b1;
    #1;
    chk(pad_out == f_out(a) && pad_oe == f_oe(a), "R11 pre-edge image",
        {pad_out, pad_oe}, {f_out(a), f_oe(a)});
    scan('0, got);
    chk(got == {1'b1, a[L-1:1]}, "R7 one-step shift", got, {1'b1, a[L-1:1]});
    chk(tdo == 1'b0, "R7 tdo after zeros", tdo, 0);
    extest = 1'b0;
  endtask

  initial begin
    fork
      begin
        #3;
        t_reset;
        #20 rst_n = 1'b1;
        @(negedge tck);
        t_core_path;
        t_capture;
        t_length;
        t_update;
        t_priority;
        t_upd_shift;
        done = 1;
      end
      begin
        repeat (20000) @(posedge tck);
        if (!done) chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule